// File: doc/BRIEF.md
# Timer Compare CSR Access Gate

This combinational block sits beside the CSR file and judges every instruction access to the two 64-bit timer compare registers: the supervisor compare register and the virtual-supervisor compare register, each reached through a low-half and a high-half address. It takes the CSR address, the current privilege level and the virtualization flag. It also takes the timer bits of the machine and hypervisor counter-enable registers and the timer-compare enable bits of the machine and hypervisor environment-config registers.

From these it raises either an illegal-instruction trap or a virtual-instruction trap, or it lets the access through. A passed access from a virtualized supervisor to the supervisor compare address is redirected, so the register file serves the virtual-supervisor copy instead.

Machine-level permission is checked first, and a failure there gives an illegal instruction. Hypervisor-level permission is checked only for guest accesses, and a failure there gives a virtual instruction. The block holds no state. Addresses other than the four compare addresses are left alone. The XLEN parameter decides whether the high-half addresses exist.

Top module: `tcmp_access_gate`

## Requirements
- R1: At machine privilege (priv code 2'b11), every compare address that exists is permitted, whatever the virtualization flag says, with no trap and no redirect.
- R2: An address other than 0x14D, 0x15D, 0x24D and 0x25D drives all three outputs low.
- R3: When XLEN is 64, the high-half addresses 0x15D and 0x25D raise illegal instruction at every privilege level. When XLEN is 32, they behave like their low halves.
- R4: User privilege (2'b00), virtualized or not, and the reserved code 2'b10 raise illegal instruction on every compare address.
- R5: Below machine privilege, a clear machine counter-enable timer bit raises illegal instruction.
- R6: Below machine privilege, a clear machine environment-config enable bit raises illegal instruction.
- R7: Host supervisor (2'b01, not virtualized) with both machine bits set is permitted on both register families, with no redirect, whatever the hypervisor bits hold.
- R8: Virtualized supervisor with both machine bits set and a clear hypervisor counter-enable timer bit raises virtual instruction on the supervisor compare addresses.
- R9: Virtualized supervisor with both machine bits set and a clear hypervisor enable bit raises virtual instruction on the supervisor compare addresses.
- R10: Virtualized supervisor with all four permission bits set is permitted on the supervisor compare addresses, and the redirect output is high.
- R11: Virtualized supervisor with both machine bits set raises virtual instruction on the virtual-supervisor addresses 0x24D and 0x25D, with no redirect.
- R12: Illegal instruction outranks virtual instruction. The two trap outputs are never high together, and redirect is high only when neither trap is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | CSR address of the access |
| priv_lvl | input | 2 | Current privilege: 00 user, 01 supervisor, 10 reserved, 11 machine |
| virt_mode | input | 1 | Virtualization active |
| mcnt_tm | input | 1 | Timer bit of the machine counter-enable register |
| hcnt_tm | input | 1 | Timer bit of the hypervisor counter-enable register |
| menv_tce | input | 1 | Timer-compare enable of the machine environment config |
| henv_tce | input | 1 | Timer-compare enable of the hypervisor environment config |
| trap_illegal | output | 1 | Raise illegal-instruction exception |
| trap_virtual | output | 1 | Raise virtual-instruction exception |
| use_vs_copy | output | 1 | Serve the virtual-supervisor compare register instead |

## Verification
The block has no stored state, so a wrong internal decision is visible on the three outputs in the same evaluation as the input change. A mistaken privilege-context classification shows up as the wrong trap kind: illegal where virtual is expected, or the reverse. A bad address decode shows up either as spurious traps on unrelated CSRs or as missing traps on high halves when XLEN is 64. A lost redirect is caught by the guest tests, where the permitted access must raise the redirect output.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        CTX_MACH,
        CTX_HOST,
        CTX_GUEST,
        CTX_UNPRIV
    } ctx_e;

    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_S_LO = 12'h14D;
    localparam logic [ADDR_W-1:0] ADDR_S_HI = 12'h15D;
    localparam logic [ADDR_W-1:0] ADDR_V_LO = 12'h24D;
    localparam logic [ADDR_W-1:0] ADDR_V_HI = 12'h25D;

    typedef struct packed {
        logic hit;     // one of the four compare addresses
        logic high;    // upper-half address
        logic vreg;    // virtual-supervisor register family
        logic absent;  // address does not exist for this XLEN
    } addr_info_t;

endpackage

// File: rtl/tcmp_addr_decode.sv
module tcmp_addr_decode
    import tcmp_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_info_t        info
);

    localparam bit HAS_HIGH = (XLEN == 32);

    logic is_s_lo, is_s_hi, is_v_lo, is_v_hi;

    always_comb begin
        is_s_lo = (addr == ADDR_S_LO);
        is_s_hi = (addr == ADDR_S_HI);
        is_v_lo = (addr == ADDR_V_LO);
        is_v_hi = (addr == ADDR_V_HI);
    end

    always_comb begin
        info.hit  = is_s_lo | is_s_hi | is_v_lo | is_v_hi;
        info.high = is_s_hi | is_v_hi;
        info.vreg = is_v_lo | is_v_hi;
    end

    generate
        if (HAS_HIGH) begin : g_narrow
            always_comb info.absent = 1'b0;
        end else begin : g_wide
            always_comb info.absent = is_s_hi | is_v_hi;
        end
    endgenerate

endmodule

// File: rtl/tcmp_perm_gate.sv
module tcmp_perm_gate (
    input  logic cnt_tm,
    input  logic env_tce,
    output logic granted
);

    always_comb granted = cnt_tm & env_tce;

endmodule

// File: rtl/tcmp_access_gate.sv
module tcmp_access_gate
    import tcmp_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [11:0] csr_addr,
    input  logic [1:0]  priv_lvl,
    input  logic        virt_mode,
    input  logic        mcnt_tm,
    input  logic        hcnt_tm,
    input  logic        menv_tce,
    input  logic        henv_tce,
    output logic        trap_illegal,
    output logic        trap_virtual,
    output logic        use_vs_copy
);

    addr_info_t info;
    logic       mach_ok;
    logic       hyp_ok;
    ctx_e       ctx;
    priv_e      priv;

    tcmp_addr_decode #(.XLEN(XLEN)) u_decode (
        .addr (csr_addr),
        .info (info)
    );

    tcmp_perm_gate u_mach_gate (
        .cnt_tm  (mcnt_tm),
        .env_tce (menv_tce),
        .granted (mach_ok)
    );

    tcmp_perm_gate u_hyp_gate (
        .cnt_tm  (hcnt_tm),
        .env_tce (henv_tce),
        .granted (hyp_ok)
    );

    always_comb begin
        priv = priv_e'(priv_lvl);
        unique case (priv)
            PRIV_M:  ctx = CTX_MACH;
            PRIV_S:  ctx = virt_mode ? CTX_GUEST : CTX_HOST;
            default: ctx = CTX_UNPRIV;
        endcase
    end

    always_comb begin
        trap_illegal = 1'b0;
        trap_virtual = 1'b0;
        use_vs_copy  = 1'b0;
        if (info.hit) begin
            if (info.absent) begin
                trap_illegal = 1'b1;
            end else begin
                unique case (ctx)
                    CTX_MACH: begin
                    end
                    CTX_HOST: begin
                        if (!mach_ok) trap_illegal = 1'b1;
                    end
                    CTX_GUEST: begin
                        if (!mach_ok)       trap_illegal = 1'b1;
                        else if (info.vreg) trap_virtual = 1'b1;
                        else if (!hyp_ok)   trap_virtual = 1'b1;
                        else                use_vs_copy  = 1'b1;
                    end
                    default: trap_illegal = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/tcmp_access_gate_chk.sv
module tcmp_access_gate_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic [11:0] csr_addr,
    input logic [1:0]  priv_lvl,
    input logic        mcnt_tm,
    input logic        menv_tce,
    input logic        trap_illegal,
    input logic        trap_virtual,
    input logic        use_vs_copy
);

    logic known_addr;
    logic high_addr;

    always_comb begin
        known_addr = (csr_addr == 12'h14D) || (csr_addr == 12'h15D) ||
                     (csr_addr == 12'h24D) || (csr_addr == 12'h25D);
        high_addr  = (csr_addr == 12'h15D) || (csr_addr == 12'h25D);
    end

    always_comb begin
        // R12
        p_traps_exclusive_r12: assert (!(trap_illegal && trap_virtual));
        // R12
        p_redirect_clean_r12: assert (!use_vs_copy || (!trap_illegal && !trap_virtual));
        // R2
        p_foreign_quiet_r2: assert (known_addr ||
                                    (!trap_illegal && !trap_virtual && !use_vs_copy));
        // R1
        p_machine_free_r1: assert (!(priv_lvl == 2'b11 && !(high_addr && XLEN == 64)) ||
                                   (!trap_illegal && !trap_virtual));
        // R3
        p_high_absent_r3: assert (!(XLEN == 64 && high_addr) || trap_illegal);
        // R4
        p_user_illegal_r4: assert (!(known_addr && !priv_lvl[0]) || trap_illegal);
        // R5 and R6
        p_mach_gate_r5: assert (!(known_addr && priv_lvl != 2'b11 && !(mcnt_tm && menv_tce))
                                || trap_illegal);
    end

endmodule

bind tcmp_access_gate tcmp_access_gate_chk #(.XLEN(XLEN)) u_chk (
    .csr_addr     (csr_addr),
    .priv_lvl     (priv_lvl),
    .mcnt_tm      (mcnt_tm),
    .menv_tce     (menv_tce),
    .trap_illegal (trap_illegal),
    .trap_virtual (trap_virtual),
    .use_vs_copy  (use_vs_copy)
);

// File: tb/tcmp_access_gate_test.sv
module tcmp_access_gate_test;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [11:0] csr_addr = '0;
    logic [1:0]  priv_lvl = '0;
    logic        virt_mode = 0, mcnt_tm = 0, hcnt_tm = 0, menv_tce = 0, henv_tce = 0;
    logic        ill64, vir64, red64, ill32, vir32, red32;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    tcmp_access_gate #(.XLEN(64)) uut (
        .csr_addr(csr_addr), .priv_lvl(priv_lvl), .virt_mode(virt_mode),
        .mcnt_tm(mcnt_tm), .hcnt_tm(hcnt_tm), .menv_tce(menv_tce), .henv_tce(henv_tce),
        .trap_illegal(ill64), .trap_virtual(vir64), .use_vs_copy(red64)
    );

    tcmp_access_gate #(.XLEN(32)) uut_rv32 (
        .csr_addr(csr_addr), .priv_lvl(priv_lvl), .virt_mode(virt_mode),
        .mcnt_tm(mcnt_tm), .hcnt_tm(hcnt_tm), .menv_tce(menv_tce), .henv_tce(henv_tce),
        .trap_illegal(ill32), .trap_virtual(vir32), .use_vs_copy(red32)
    );

    task automatic drive(input logic [11:0] a, input logic [1:0] p, input logic v,
                         input logic mt, input logic me, input logic ht, input logic he);
        @(negedge clk);
        csr_addr = a; priv_lvl = p; virt_mode = v;
        mcnt_tm = mt; menv_tce = me; hcnt_tm = ht; henv_tce = he;
        #1;
    endtask

    task automatic expect_out(input string req, input bit w32,
                              input logic ei, input logic ev, input logic er);
        logic [2:0] got;
        got = w32 ? {ill32, vir32, red32} : {ill64, vir64, red64};
        checks++;
        if (got !== {ei, ev, er}) begin
            errors++;
            $display("FAIL %s xlen%0d addr=%h priv=%b v=%b: got ill/vir/red=%b expected %b",
                     req, w32 ? 32 : 64, csr_addr, priv_lvl, virt_mode, got, {ei, ev, er});
        end
    endtask

    task automatic test_reset_state();
        drive(12'h000, 2'b00, 0, 0, 0, 0, 0);
        expect_out("R2 reset", 0, 0, 0, 0);
        expect_out("R2 reset", 1, 0, 0, 0);
    endtask

    task automatic test_machine();
        foreach (uut_addrs[i]) begin
            drive(uut_addrs[i], 2'b11, 1, 0, 0, 0, 0);
            expect_out("R1", 1, 0, 0, 0);
        end
        drive(12'h14D, 2'b11, 0, 0, 0, 0, 0);
        expect_out("R1", 0, 0, 0, 0);
        drive(12'h24D, 2'b11, 1, 0, 0, 0, 0);
        expect_out("R1", 0, 0, 0, 0);
    endtask

    task automatic test_foreign();
        drive(12'h14C, 2'b00, 0, 0, 0, 0, 0);
        expect_out("R2", 0, 0, 0, 0);
        drive(12'h34D, 2'b01, 1, 1, 1, 1, 1);
        expect_out("R2", 1, 0, 0, 0);
        drive(12'h105, 2'b01, 1, 0, 0, 0, 0);
        expect_out("R2", 0, 0, 0, 0);
    endtask

    task automatic test_high_half();
        for (int p = 0; p < 4; p++) begin
            drive(12'h15D, 2'(p), 0, 1, 1, 1, 1);
            expect_out("R3", 0, 1, 0, 0);
            drive(12'h25D, 2'(p), 1, 1, 1, 1, 1);
            expect_out("R3", 0, 1, 0, 0);
        end
        drive(12'h15D, 2'b01, 1, 1, 1, 1, 1);
        expect_out("R3 rv32 high", 1, 0, 0, 1);
        drive(12'h25D, 2'b01, 0, 1, 1, 0, 0);
        expect_out("R3 rv32 high", 1, 0, 0, 0);
    endtask

    task automatic test_user();
        drive(12'h14D, 2'b00, 0, 1, 1, 1, 1);
        expect_out("R4", 0, 1, 0, 0);
        drive(12'h14D, 2'b00, 1, 1, 1, 1, 1);
        expect_out("R4", 0, 1, 0, 0);
        drive(12'h24D, 2'b10, 0, 1, 1, 1, 1);
        expect_out("R4", 0, 1, 0, 0);
    endtask

    task automatic test_machine_gate();
        drive(12'h14D, 2'b01, 0, 0, 1, 1, 1);
        expect_out("R5", 0, 1, 0, 0);
        drive(12'h14D, 2'b01, 1, 0, 1, 1, 1);
        expect_out("R5", 0, 1, 0, 0);
        drive(12'h14D, 2'b01, 0, 1, 0, 1, 1);
        expect_out("R6", 0, 1, 0, 0);
        drive(12'h24D, 2'b01, 1, 1, 0, 1, 1);
        expect_out("R6", 0, 1, 0, 0);
    endtask

    task automatic test_host();
        drive(12'h14D, 2'b01, 0, 1, 1, 0, 0);
        expect_out("R7", 0, 0, 0, 0);
        drive(12'h24D, 2'b01, 0, 1, 1, 0, 0);
        expect_out("R7", 0, 0, 0, 0);
        drive(12'h25D, 2'b01, 0, 1, 1, 1, 1);
        expect_out("R7", 1, 0, 0, 0);
    endtask

    task automatic test_guest();
        drive(12'h14D, 2'b01, 1, 1, 1, 0, 1);
        expect_out("R8", 0, 0, 1, 0);
        drive(12'h14D, 2'b01, 1, 1, 1, 1, 0);
        expect_out("R9", 0, 0, 1, 0);
        drive(12'h14D, 2'b01, 1, 1, 1, 1, 1);
        expect_out("R10", 0, 0, 0, 1);
        expect_out("R10", 1, 0, 0, 1);
        drive(12'h24D, 2'b01, 1, 1, 1, 1, 1);
        expect_out("R11", 0, 0, 1, 0);
        drive(12'h25D, 2'b01, 1, 1, 1, 0, 0);
        expect_out("R11", 1, 0, 1, 0);
        drive(12'h14D, 2'b01, 1, 0, 1, 0, 0);
        expect_out("R12 priority", 0, 1, 0, 0);
    endtask

    task automatic test_exclusive_sweep();
        for (int a = 0; a < 4; a++) begin
            for (int k = 0; k < 128; k++) begin
                logic [11:0] ad;
                ad = uut_addrs[a];
                drive(ad, k[1:0], k[2], k[3], k[4], k[5], k[6]);
                checks++;
                if ((ill64 && vir64) || (red64 && (ill64 || vir64)) ||
                    (ill32 && vir32) || (red32 && (ill32 || vir32))) begin
                    errors++;
                    $display("FAIL R12 addr=%h k=%0d: got %b%b%b/%b%b%b expected exclusive",
                             ad, k, ill64, vir64, red64, ill32, vir32, red32);
                end
            end
        end
    endtask

    logic [11:0] uut_addrs [4] = '{12'h14D, 12'h15D, 12'h24D, 12'h25D};

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        test_reset_state();
        test_machine();
        test_foreign();
        test_high_half();
        test_user();
        test_machine_gate();
        test_host();
        test_guest();
        test_exclusive_sweep();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule